// File: doc/BRIEF.md
# DRAM Self-Refresh Entry Controller

This block decides when the memory controller may ask the DRAM to enter self-refresh and when that request must be withdrawn. A free-running prescaler divides the core clock into a 250 ns tick. Every delay and latency in the configuration word is counted in units of this tick. Each isochronous request arrives as a one-cycle valid strobe that carries the latency the requester can tolerate. That latency is compared against two programmed limits. The first marks the request as high priority. The second decides whether the request forbids self-refresh altogether.

Entry happens only when all of the following hold: dynamic self-refresh is enabled, the request stream has been quiet for a programmed number of ticks, and the optional interlock is not active. The interlock blocks entry while the buffer is full and an urgent request is stalled at admission. Exit happens when dynamic self-refresh is switched off, or when a request arrives whose tolerance is below the threshold. In the second case the request level falls in the same cycle. The exit-latency field is not used inside the block. It is passed out for the rest of the memory controller.

Top module: `srefctl`

## Requirements
- R1: After reset, `sr_req` is 0 and the configuration holds its defaults: exit latency 12 (`exit_lat` = 12), priority limit 8, idle delay 4, interlock off, hold-off threshold 40.
- R2: A cycle with `cfg_we` high loads `cfg_din` into the configuration on the next edge. The fields are: bits 6:0 exit latency, bits 11:8 priority limit, bits 17:12 idle delay, bit 18 interlock enable, bits 31:22 hold-off threshold. Bits 7 and 21:19 are reserved. `exit_lat` shows bits 6:0.
- R3: `req_hipri` is 1 exactly when `req_valid` is 1 and `req_lat` is below the priority limit. An equal or larger latency gives 0, and so does no request.
- R4: With `sr_en` high and no requests, `sr_req` rises once the idle counter has seen as many 250 ns ticks as the idle-delay field gives (one tick every `TICK_DIV` clocks), plus one register stage. It does not rise earlier.
- R5: With `sr_en` high, an idle delay of 0 or 1 behaves as 2.
- R6: A request whose `req_lat` is below the hold-off threshold forces `sr_req` to 0 in the same cycle. The request level stays low until a new full idle delay has passed.
- R7: Any request clears the idle counter, so entry is pushed back by a full delay. A request at or above the threshold does not lower an `sr_req` that is already high.
- R8: When the interlock bit is 1, `sr_req` does not rise while `buf_full` and `hp_blocked` are both 1. When the interlock bit is 0, those flags have no effect.
- R9: With `sr_en` low, `sr_req` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_en | input | 1 | Dynamic self-refresh enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_din | input | 32 | Configuration word to load |
| req_valid | input | 1 | Isochronous request strobe |
| req_lat | input | 10 | Latency the request tolerates, in 250 ns units |
| buf_full | input | 1 | Request buffer is full |
| hp_blocked | input | 1 | An urgent request is stalled at admission |
| sr_req | output | 1 | Self-refresh request level |
| req_hipri | output | 1 | The current request is high priority |
| exit_lat | output | 7 | Programmed exit-latency budget |

## Verification
Two functions can act in the same cycle: the entry decision and the immediate hold-off. The bench provokes this by driving a low-latency request while `sr_req` is high. It then checks the output within that same cycle, before the next edge, so the combinational drop is seen together with the registered state. A second collision comes from a tolerant request that arrives while `sr_req` is high. Here the idle counter is cleared but the level must stay up. After this, a check made partway through a fresh delay window shows that entry was pushed back to a full delay.

// File: rtl/srefctl.sv
module srefctl #(
  parameter int CLK_MHZ   = 250,
  parameter int LAT_W     = 10,
  parameter int DEF_EXIT  = 12,
  parameter int DEF_SCHED = 8,
  parameter int DEF_DLY   = 4,
  parameter int DEF_THR   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_en,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_din,
  input  logic             req_valid,
  input  logic [LAT_W-1:0] req_lat,
  input  logic             buf_full,
  input  logic             hp_blocked,
  output logic             sr_req,
  output logic             req_hipri,
  output logic [6:0]       exit_lat
);
  localparam int TDIV_RAW = (CLK_MHZ * 250 + 999) / 1000;
  localparam int TICK_DIV = (TDIV_RAW < 1) ? 1 : TDIV_RAW;
  localparam int TW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [31:0] CFG_MASK = 32'hFFC7_FF7F;
  localparam logic [31:0] CFG_DEF  = {DEF_THR[9:0], 3'b000, 1'b0, DEF_DLY[5:0],
                                      DEF_SCHED[3:0], 1'b0, DEF_EXIT[6:0]};

  logic [31:0]   cfg_q;
  logic [TW-1:0] tcnt;
  logic          tick;
  logic [5:0]    idle_cnt;
  logic          sr_q;

  wire [3:0] sched  = cfg_q[11:8];
  wire [5:0] dly    = cfg_q[17:12];
  wire       sync   = cfg_q[18];
  wire [9:0] thresh = cfg_q[31:22];

  wire [5:0] dly_eff = (dly < 6'd2) ? 6'd2 : dly;
  wire       hold    = req_valid && ({{(32-LAT_W){1'b0}}, req_lat} < {22'd0, thresh});
  wire       blk     = sync && buf_full && hp_blocked;
  wire       ready   = (idle_cnt >= dly_eff) && !req_valid && !blk && sr_en;

  assign exit_lat  = cfg_q[6:0];
  assign req_hipri = req_valid && ({{(32-LAT_W){1'b0}}, req_lat} < {28'd0, sched});
  assign sr_req    = sr_q && !hold;

  generate
    if (TICK_DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (!rst_n)                              tcnt <= '0;
        else if (tcnt == TW'(TICK_DIV - 1))      tcnt <= '0;
        else                                     tcnt <= tcnt + 1'b1;
      end
      assign tick = (tcnt == TW'(TICK_DIV - 1));
    end else begin : g_nodiv
      always_ff @(posedge clk) tcnt <= '0;
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_DEF;
    else if (cfg_we) cfg_q <= cfg_din & CFG_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || req_valid)          idle_cnt <= '0;
    else if (tick && idle_cnt < 6'd63) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sr_en || hold) sr_q <= 1'b0;
    else if (ready)               sr_q <= 1'b1;
  end
endmodule

// File: rtl/srefctl_chk.sv
module srefctl_chk #(
  parameter int LAT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sr_en,
  input logic             req_valid,
  input logic [LAT_W-1:0] req_lat,
  input logic             buf_full,
  input logic             hp_blocked,
  input logic             sr_req,
  input logic             req_hipri,
  input logic [31:0]      cfg_q,
  input logic             sr_q,
  input logic [5:0]       idle_cnt
);
  AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && {{(32-LAT_W){1'b0}}, req_lat} < {22'd0, cfg_q[31:22]}) |-> !sr_req); // R6
  AST_HIPRI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_hipri |-> req_valid); // R3
  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_en |=> !sr_req); // R9
  AST_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_q) |-> !$past(cfg_q[18] && buf_full && hp_blocked)); // R8
  AST_MIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_q) |-> ($past(idle_cnt) >= 6'd2 && !$past(req_valid))); // R5
  AST_ENTRY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_q) |-> $past(sr_en)); // R4
endmodule

bind srefctl srefctl_chk #(.LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .req_valid(req_valid), .req_lat(req_lat),
  .buf_full(buf_full), .hp_blocked(hp_blocked), .sr_req(sr_req), .req_hipri(req_hipri),
  .cfg_q(cfg_q), .sr_q(sr_q), .idle_cnt(idle_cnt)
);

// File: tb/test_srefctl.sv
module test_srefctl;
  logic clk = 0, rst_n = 0, sr_en = 0, cfg_we = 0, req_valid = 0, buf_full = 0, hp_blocked = 0;
  logic [31:0] cfg_din = '0;
  logic [9:0]  req_lat = '0;
  logic sr_req, req_hipri;
  logic [6:0] exit_lat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  srefctl #(.CLK_MHZ(16)) i_srefctl (
    .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .req_valid(req_valid), .req_lat(req_lat), .buf_full(buf_full), .hp_blocked(hp_blocked),
    .sr_req(sr_req), .req_hipri(req_hipri), .exit_lat(exit_lat)
  );

  localparam logic [10:0] VEC [6] = '{
    {10'd0, 1'b1}, {10'd7, 1'b1}, {10'd8, 1'b0},
    {10'd9, 1'b0}, {10'd200, 1'b0}, {10'd1023, 1'b0}
  };

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(int ex, int sc, int dl, int sy, int th);
    return {th[9:0], 3'b000, sy[0], dl[5:0], sc[3:0], 1'b0, ex[6:0]};
  endfunction

  task automatic wcfg(logic [31:0] w);
    cfg_din = w; cfg_we = 1; step(1); cfg_we = 0;
  endtask

  task automatic pulse(logic [9:0] lat);
    req_valid = 1; req_lat = lat; step(1); req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 sr_req in reset", sr_req, 0);
    chk("R1 exit_lat default", exit_lat, 12);
    rst_n = 1; step(1);
    chk("R1 sr_req after reset", sr_req, 0);

    foreach (VEC[i]) begin
      req_valid = 1; req_lat = VEC[i][10:1]; #1;
      chk($sformatf("R3 hipri lat %0d", VEC[i][10:1]), req_hipri, VEC[i][0]);
      step(1);
    end
    req_valid = 0; req_lat = 0; #1;
    chk("R3 hipri no request", req_hipri, 0);

    wcfg(mk(36, 3, 5, 0, 20) | 32'h0038_0080);
    chk("R2 exit_lat written", exit_lat, 36);
    req_valid = 1; req_lat = 2; #1; chk("R2 new sched lat 2", req_hipri, 1);
    req_lat = 3; #1; chk("R2 new sched lat 3", req_hipri, 0);
    req_valid = 0;

    sr_en = 1; pulse(500);
    step(16); chk("R4 not yet entered", sr_req, 0);
    step(4);  chk("R4 entered after delay", sr_req, 1);

    pulse(500);
    chk("R7 tolerant request keeps sr_req", sr_req, 1);
    step(3); chk("R7 still high after tolerant request", sr_req, 1);

    req_valid = 1; req_lat = 5; #1;
    chk("R6 drop in same cycle", sr_req, 0);
    step(3); chk("R6 held low", sr_req, 0);
    req_valid = 0; #1;
    chk("R6 stays low after hold-off", sr_req, 0);

    sr_en = 0; step(1); chk("R9 disabled", sr_req, 0);
    sr_en = 1; pulse(500);
    step(10); pulse(500);
    step(16); chk("R7 entry pushed back", sr_req, 0);
    step(4);  chk("R7 entry after restart", sr_req, 1);
    sr_en = 0; step(1); chk("R9 drop when disabled", sr_req, 0);
    step(30); chk("R9 stays low idle", sr_req, 0);

    wcfg(mk(12, 8, 0, 0, 20));
    sr_en = 1; pulse(500);
    step(4); chk("R5 delay 0 clamped early", sr_req, 0);
    step(4); chk("R5 delay 0 clamped entry", sr_req, 1);
    sr_en = 0; step(1);
    wcfg(mk(12, 8, 1, 0, 20));
    sr_en = 1; pulse(500);
    step(4); chk("R5 delay 1 clamped early", sr_req, 0);
    step(4); chk("R5 delay 1 clamped entry", sr_req, 1);

    sr_en = 0; step(1);
    wcfg(mk(12, 8, 2, 1, 20));
    buf_full = 1; hp_blocked = 1;
    sr_en = 1; pulse(500);
    step(20); chk("R8 interlock blocks entry", sr_req, 0);
    hp_blocked = 0; step(2);
    chk("R8 entry after unblock", sr_req, 1);

    sr_en = 0; step(1);
    wcfg(mk(12, 8, 2, 0, 20));
    hp_blocked = 1;
    sr_en = 1; pulse(500);
    step(12); chk("R8 flags ignored without interlock", sr_req, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule